// File: doc/BRIEF.md
# Set-Associative Page Translation Cache with Test Registers

The block caches linear-to-physical page translations in four ways of eight sets. A normal lookup port takes a 20-bit linear page number and reports in the same cycle whether it hits, along with the physical page and the three page attributes (dirty, user, writable). Translations enter through a fill port, which places them in the way named by a per-set round-robin pointer. A flush input invalidates every entry at once.

Alongside the normal path, a two-register test port lets software drive the array directly. Loading the command register either writes one entry into a chosen way or performs a lookup whose result is placed in the data register. Test lookups can filter on attributes. Each attribute has a true bit and a complement bit that together form a match mask. Test writes are accepted only when the hit flag in the data register is set, so a stale data register cannot corrupt the array by accident.

Top module: `tlb_cache`

## Requirements
- R1: After reset no entry is valid, `lk_hit_o` is 0, and `cmd_o` and `data_o` both read as zero.
- R2: Linear page bits [2:0] select one of 8 sets. The remaining 17 bits are the tag. A page hits only if a valid entry in its own set holds an equal tag.
- R3: A normal lookup is combinational. On a hit it drives `lk_ppn_o` and `lk_attr_o` ({dirty,user,writable}) from the lowest-numbered matching way. On a miss `lk_ppn_o` is zero.
- R4: Each fill writes a valid entry into the way given by its set's replacement pointer. The pointer then advances by one, modulo 4. Pointers start at 0, and each set's pointer moves only when that set is filled.
- R5: A flush makes every lookup miss from the next cycle on. The replacement pointers are left unchanged.
- R6: Command register layout: bit 0 is the opcode (0 write, 1 lookup), bits 31:12 the linear page, bit 11 valid, and bits 10:5 the pairs {D,D#,U,U#,W,W#}. Bits 4:1 read as zero. The command is carried out at the clock edge that loads it, and `cmd_o` reads back the loaded value.
- R7: A test write takes effect only when data register bit 4 (hit) is 1. It fills set lpn[2:0], in the way given by data bits 3:2, with the tag, the valid bit, the true attribute bits and the physical page in data bits 31:12. When bit 4 is 0 the array is not changed.
- R8: A test lookup that matches exactly one entry sets data bit 4 to 1, bits 31:12 to the physical page and bits 3:2 to the way.
- R9: In a test lookup, each attribute pair selects entries as follows: 10 requires the attribute to be 1, 01 requires 0, 11 matches either value, and 00 matches nothing.
- R10: A test lookup with zero matches, or with more than one, clears data bit 4 and leaves the page and way fields unchanged.
- R11: Flush takes priority over an effective test write, which takes priority over a fill. A dropped fill does not move the pointer.
- R12: Loading the data register stores bits 31:12, 4 and 3:2; all other bits read as zero. If a test lookup is loaded in the same cycle, the lookup result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_lpn_i | input | 20 | Linear page for the normal lookup |
| lk_hit_o | output | 1 | Normal lookup hit |
| lk_ppn_o | output | 20 | Physical page on hit, zero on miss |
| lk_attr_o | output | 3 | {dirty,user,writable} of the hit entry |
| fill_i | input | 1 | Fill request |
| fill_lpn_i | input | 20 | Linear page to fill |
| fill_ppn_i | input | 20 | Physical page to fill |
| fill_attr_i | input | 3 | Attributes to fill |
| flush_i | input | 1 | Invalidate all entries |
| cmd_we_i | input | 1 | Load command register and execute |
| cmd_i | input | 32 | Command register value |
| data_we_i | input | 1 | Load data register |
| data_i | input | 32 | Data register value |
| cmd_o | output | 32 | Command register readback |
| data_o | output | 32 | Data register readback |

## Verification
Two write sources can compete for the array in a single cycle: a fill and an effective test write. The flush can also coincide with either of them. The bench provokes each collision by asserting both strobes in one cycle. It then judges the outcome only through lookups: whether the written page hits, and which way the next fill in that set is reported in by a test lookup. Both results tell whether the dropped fill moved the pointer. A further collision pairs a data register load with a test lookup, and the bench checks that the lookup result is what `data_o` shows.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned PG_LO      = 12;
  localparam int unsigned CMD_OP     = 0;
  localparam int unsigned CMD_WN     = 5;
  localparam int unsigned CMD_W      = 6;
  localparam int unsigned CMD_UN     = 7;
  localparam int unsigned CMD_U      = 8;
  localparam int unsigned CMD_DN     = 9;
  localparam int unsigned CMD_D      = 10;
  localparam int unsigned CMD_VLD    = 11;
  localparam int unsigned DAT_WAY_LO = 2;
  localparam int unsigned DAT_HIT    = 4;

  typedef struct packed {
    logic dirty;
    logic user;
    logic rw;
  } tlb_attr_t;

  typedef enum logic {
    OP_WRITE  = 1'b0,
    OP_LOOKUP = 1'b1
  } tlb_op_e;
endpackage

// File: rtl/tlb_way_match.sv
module tlb_way_match
  import tlb_pkg::*;
#(
  parameter int unsigned TAG_W = 17
) (
  input  logic             vld_i,
  input  logic [TAG_W-1:0] tag_i,
  input  tlb_attr_t        attr_i,
  input  logic [TAG_W-1:0] key_i,
  input  logic [5:0]       pair_i,
  output logic             hit_o
);
  logic d_ok, u_ok, w_ok;

  // pair = {true, complement}: true admits 1, complement admits 0
  assign d_ok  = (pair_i[5] & attr_i.dirty) | (pair_i[4] & ~attr_i.dirty);
  assign u_ok  = (pair_i[3] & attr_i.user)  | (pair_i[2] & ~attr_i.user);
  assign w_ok  = (pair_i[1] & attr_i.rw)    | (pair_i[0] & ~attr_i.rw);
  assign hit_o = vld_i && (tag_i == key_i) && d_ok && u_ok && w_ok;
endmodule

// File: rtl/tlb_hit_pick.sv
module tlb_hit_pick #(
  parameter int unsigned WAYS = 4,
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned CNT_W = $clog2(WAYS + 1)
) (
  input  logic [WAYS-1:0]  hits_i,
  output logic             any_o,
  output logic             one_o,
  output logic [WAY_W-1:0] idx_o
);
  logic [CNT_W-1:0] cnt;

  always_comb begin
    idx_o = '0;
    cnt   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hits_i[w]) begin
        idx_o = WAY_W'(w);
        cnt   = cnt + 1'b1;
      end
    end
  end

  assign any_o = |hits_i;
  assign one_o = (cnt == CNT_W'(1));
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int unsigned SETS = 8,
  parameter int unsigned WAYS = 4,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [SET_W-1:0] set_i,
  output logic [WAY_W-1:0] way_o
);
  logic [SETS-1:0][WAY_W-1:0] ptr_q;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_q[s] <= '0;
      end else if (adv_i && set_i == SET_W'(s)) begin
        ptr_q[s] <= (ptr_q[s] == WAY_W'(WAYS - 1)) ? '0 : ptr_q[s] + 1'b1;
      end
    end
  end

  assign way_o = ptr_q[set_i];

  p_rr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> ptr_q[$past(set_i)] ==
      (($past(way_o) == WAY_W'(WAYS - 1)) ? '0 : $past(way_o) + 1'b1));

  p_rr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_q));
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
  import tlb_pkg::*;
#(
  parameter int unsigned SETS  = 8,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned LPN_W = 20,
  parameter int unsigned PPN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LPN_W-1:0] lk_lpn_i,
  output logic             lk_hit_o,
  output logic [PPN_W-1:0] lk_ppn_o,
  output logic [2:0]       lk_attr_o,
  input  logic             fill_i,
  input  logic [LPN_W-1:0] fill_lpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic [2:0]       fill_attr_i,
  input  logic             flush_i,
  input  logic             cmd_we_i,
  input  logic [31:0]      cmd_i,
  input  logic             data_we_i,
  input  logic [31:0]      data_i,
  output logic [31:0]      cmd_o,
  output logic [31:0]      data_o
);
  localparam int unsigned SET_W = $clog2(SETS);
  localparam int unsigned WAY_W = $clog2(WAYS);
  localparam int unsigned TAG_W = LPN_W - SET_W;
  localparam logic [REG_W-1:0] CMD_MASK =
    {{(REG_W - CMD_WN){1'b1}}, {(CMD_WN - 1){1'b0}}, 1'b1};

  // storage
  logic [SETS-1:0][WAYS-1:0] vld_q;
  logic [TAG_W-1:0]          tag_q  [SETS][WAYS];
  logic [PPN_W-1:0]          ppn_q  [SETS][WAYS];
  tlb_attr_t                 attr_q [SETS][WAYS];

  // test registers
  logic [REG_W-1:0] cmd_q;
  logic [PPN_W-1:0] dppn_q;
  logic             dhit_q;
  logic [WAY_W-1:0] dway_q;

  // decoded test command
  logic             test_wr, test_rd, wr_ok;
  logic [LPN_W-1:0] t_lpn;
  logic [SET_W-1:0] t_set;
  logic [TAG_W-1:0] t_tag;
  logic [WAY_W-1:0] t_way;
  tlb_attr_t        t_attr;

  assign test_wr = cmd_we_i && (tlb_op_e'(cmd_i[CMD_OP]) == OP_WRITE);
  assign test_rd = cmd_we_i && (tlb_op_e'(cmd_i[CMD_OP]) == OP_LOOKUP);
  assign wr_ok   = test_wr && dhit_q;
  assign t_lpn   = cmd_i[PG_LO +: LPN_W];
  assign t_set   = t_lpn[SET_W-1:0];
  assign t_tag   = t_lpn[LPN_W-1:SET_W];
  assign t_way   = dway_q;
  assign t_attr  = '{dirty: cmd_i[CMD_D], user: cmd_i[CMD_U], rw: cmd_i[CMD_W]};

  // fill path
  logic             fill_go;
  logic [SET_W-1:0] f_set;
  logic [TAG_W-1:0] f_tag;
  logic [WAY_W-1:0] rr_way;

  assign f_set   = fill_lpn_i[SET_W-1:0];
  assign f_tag   = fill_lpn_i[LPN_W-1:SET_W];
  assign fill_go = fill_i && !flush_i && !wr_ok;

  tlb_rr_ptr #(.SETS(SETS), .WAYS(WAYS)) u_rr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (fill_go),
    .set_i  (f_set),
    .way_o  (rr_way)
  );

  // match paths
  logic [SET_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  logic [WAYS-1:0]  lk_hits, t_hits;
  logic             lk_any, lk_one_unused, t_any_unused, t_one;
  logic [WAY_W-1:0] lk_idx, t_idx;

  assign lk_set = lk_lpn_i[SET_W-1:0];
  assign lk_tag = lk_lpn_i[LPN_W-1:SET_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tlb_way_match #(.TAG_W(TAG_W)) u_lk (
      .vld_i  (vld_q[lk_set][w]),
      .tag_i  (tag_q[lk_set][w]),
      .attr_i (attr_q[lk_set][w]),
      .key_i  (lk_tag),
      .pair_i (6'b111111),
      .hit_o  (lk_hits[w])
    );
    tlb_way_match #(.TAG_W(TAG_W)) u_ts (
      .vld_i  (vld_q[t_set][w]),
      .tag_i  (tag_q[t_set][w]),
      .attr_i (attr_q[t_set][w]),
      .key_i  (t_tag),
      .pair_i (cmd_i[CMD_WN +: 6]),
      .hit_o  (t_hits[w])
    );
  end

  tlb_hit_pick #(.WAYS(WAYS)) u_lk_pick (
    .hits_i (lk_hits),
    .any_o  (lk_any),
    .one_o  (lk_one_unused),
    .idx_o  (lk_idx)
  );

  tlb_hit_pick #(.WAYS(WAYS)) u_ts_pick (
    .hits_i (t_hits),
    .any_o  (t_any_unused),
    .one_o  (t_one),
    .idx_o  (t_idx)
  );

  assign lk_hit_o  = lk_any;
  assign lk_ppn_o  = lk_any ? ppn_q[lk_set][lk_idx] : '0;
  assign lk_attr_o = lk_any ? attr_q[lk_set][lk_idx] : '0;

  // valid bits: flush > test write > fill
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
    end else if (wr_ok) begin
      vld_q[t_set][t_way] <= cmd_i[CMD_VLD];
    end else if (fill_go) begin
      vld_q[f_set][rr_way] <= 1'b1;
    end
  end

  // payload needs no reset: qualified by vld_q
  always_ff @(posedge clk_i) begin
    if (wr_ok) begin
      tag_q[t_set][t_way]  <= t_tag;
      ppn_q[t_set][t_way]  <= dppn_q;
      attr_q[t_set][t_way] <= t_attr;
    end else if (fill_go) begin
      tag_q[f_set][rr_way]  <= f_tag;
      ppn_q[f_set][rr_way]  <= fill_ppn_i;
      attr_q[f_set][rr_way] <= tlb_attr_t'(fill_attr_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      dppn_q <= '0;
      dhit_q <= 1'b0;
      dway_q <= '0;
    end else begin
      if (cmd_we_i) cmd_q <= cmd_i & CMD_MASK;
      if (test_rd) begin
        dhit_q <= t_one;
        if (t_one) begin
          dppn_q <= ppn_q[t_set][t_idx];
          dway_q <= t_idx;
        end
      end else if (data_we_i) begin
        dppn_q <= data_i[PG_LO +: PPN_W];
        dhit_q <= data_i[DAT_HIT];
        dway_q <= data_i[DAT_WAY_LO +: WAY_W];
      end
    end
  end

  assign cmd_o  = cmd_q;
  assign data_o = {dppn_q, {(PG_LO - DAT_HIT - 1){1'b0}}, dhit_q, dway_q,
                   {DAT_WAY_LO{1'b0}}};

  p_flush_empties_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !lk_hit_o);

  p_miss_ppn_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> lk_ppn_o == '0);

  p_guarded_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_wr && !dhit_q && !flush_i && !fill_i) |=> $stable(vld_q));

  p_multi_miss_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_rd && $countones(t_hits) > 1) |=> !data_o[DAT_HIT]);

  p_fill_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_go |=> vld_q[$past(f_set)][$past(rr_way)]);

  p_flush_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> vld_q == '0);
endmodule

// File: tb/tlb_cache_test.sv
module tlb_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] lk_lpn = '0;
  logic        lk_hit;
  logic [19:0] lk_ppn;
  logic [2:0]  lk_attr;
  logic        fill = 1'b0;
  logic [19:0] fill_lpn = '0;
  logic [19:0] fill_ppn = '0;
  logic [2:0]  fill_attr = '0;
  logic        flush = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd = '0;
  logic        data_we = 1'b0;
  logic [31:0] data = '0;
  logic [31:0] cmd_rb, data_rb;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // bench model
  bit          mv [8][4];
  logic [19:0] ml [8][4];
  logic [19:0] mp [8][4];
  logic [2:0]  ma [8][4];
  int          mptr [8];
  logic [31:0] mdat = '0;

  always #5 clk = ~clk;

  tlb_cache uut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_lpn_i(lk_lpn), .lk_hit_o(lk_hit), .lk_ppn_o(lk_ppn), .lk_attr_o(lk_attr),
    .fill_i(fill), .fill_lpn_i(fill_lpn), .fill_ppn_i(fill_ppn), .fill_attr_i(fill_attr),
    .flush_i(flush), .cmd_we_i(cmd_we), .cmd_i(cmd), .data_we_i(data_we), .data_i(data),
    .cmd_o(cmd_rb), .data_o(data_rb)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
    fill = 1'b0; flush = 1'b0; cmd_we = 1'b0; data_we = 1'b0;
  endtask

  function automatic logic [31:0] mk_cmd(logic [19:0] lpn, logic v, logic [5:0] pr, logic op);
    return {lpn, v, pr, 4'b0, op};
  endfunction

  function automatic logic [31:0] mk_dat(logic [19:0] ppn, logic h, logic [1:0] w);
    return {ppn, 7'b0, h, w, 2'b0};
  endfunction

  function automatic bit pair_ok(logic [2:0] a, logic [5:0] pr);
    bit ok = 1'b1;
    for (int i = 0; i < 3; i++) begin
      logic bitv = a[2-i];
      logic t = pr[5-2*i];
      logic c = pr[4-2*i];
      if (!((t && bitv) || (c && !bitv))) ok = 1'b0;
    end
    return ok;
  endfunction

  task automatic m_fill(logic [19:0] lpn, logic [19:0] ppn, logic [2:0] a);
    int s = int'(lpn[2:0]);
    int w = mptr[s];
    mv[s][w] = 1'b1; ml[s][w] = lpn; mp[s][w] = ppn; ma[s][w] = a;
    mptr[s] = (w + 1) % 4;
  endtask

  task automatic do_fill(logic [19:0] lpn, logic [19:0] ppn, logic [2:0] a);
    fill = 1'b1; fill_lpn = lpn; fill_ppn = ppn; fill_attr = a;
    cyc();
    m_fill(lpn, ppn, a);
  endtask

  task automatic check_lk(string req, logic [19:0] lpn);
    int s = int'(lpn[2:0]);
    bit h = 1'b0;
    logic [19:0] ep = '0;
    logic [2:0] ea = '0;
    lk_lpn = lpn;
    #1;
    for (int w = 3; w >= 0; w--)
      if (mv[s][w] && ml[s][w] == lpn) begin h = 1'b1; ep = mp[s][w]; ea = ma[s][w]; end
    check({req, " lk hit"}, 32'(lk_hit), 32'(h));
    check({req, " lk ppn"}, 32'(lk_ppn), 32'(ep));
    if (h) check({req, " lk attr"}, 32'(lk_attr), 32'(ea));
  endtask

  task automatic set_data(logic [31:0] d);
    data = d; data_we = 1'b1;
    cyc();
    mdat = d & 32'hFFFF_F01C;
  endtask

  task automatic m_write(logic [19:0] lpn, logic v, logic [5:0] pr);
    if (mdat[4]) begin
      int s = int'(lpn[2:0]);
      int w = int'(mdat[3:2]);
      mv[s][w] = v; ml[s][w] = lpn; mp[s][w] = mdat[31:12];
      ma[s][w] = {pr[5], pr[3], pr[1]};
    end
  endtask

  task automatic t_write(logic [19:0] lpn, logic v, logic [5:0] pr);
    cmd = mk_cmd(lpn, v, pr, 1'b0); cmd_we = 1'b1;
    cyc();
    m_write(lpn, v, pr);
  endtask

  task automatic t_lookup(string req, logic [19:0] lpn, logic [5:0] pr);
    int s = int'(lpn[2:0]);
    int n = 0;
    int fw = 0;
    cmd = mk_cmd(lpn, 1'b0, pr, 1'b1); cmd_we = 1'b1;
    cyc();
    for (int w = 0; w < 4; w++)
      if (mv[s][w] && ml[s][w] == lpn && pair_ok(ma[s][w], pr)) begin n++; fw = w; end
    if (n == 1) mdat = mk_dat(mp[s][fw], 1'b1, 2'(fw));
    else        mdat[4] = 1'b0;
    check({req, " test lookup"}, data_rb, mdat);
  endtask

  function automatic logic [19:0] lpn_of(int s, int k);
    return 20'(((s * 7 + k + 1) << 3) | s);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 8; s++) begin
      mptr[s] = 0;
      for (int w = 0; w < 4; w++) begin mv[s][w] = 1'b0; ml[s][w] = '0; mp[s][w] = '0; ma[s][w] = '0; end
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    cyc();

    // R1 reset state
    check_lk("R1", 20'h0);
    check("R1 cmd", cmd_rb, 32'h0);
    check("R1 data", data_rb, 32'h0);

    // R2 R3 R4: fill every way of every set, read all back
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 4; k++)
        do_fill(lpn_of(s, k), 20'hA0000 ^ 20'((s << 4) | k), 3'((s + k) % 8));
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 4; k++) check_lk("R2 R3", lpn_of(s, k));
    check_lk("R2 foreign tag", 20'hFFFF8);
    // R4 fifth fill per set evicts the oldest
    for (int s = 0; s < 8; s++) do_fill(lpn_of(s, 9), 20'h5000 + 20'(s), 3'(s));
    for (int s = 0; s < 8; s++) begin
      check_lk("R4 evicted", lpn_of(s, 0));
      check_lk("R4 new", lpn_of(s, 9));
      check_lk("R4 kept", lpn_of(s, 1));
    end

    // R8 test lookups of all live entries
    for (int s = 0; s < 8; s++)
      for (int k = 1; k < 4; k++) t_lookup("R8", lpn_of(s, k), 6'b111111);
    t_lookup("R10 zero match", 20'hFFFF8, 6'b111111);

    // R9 all pair encodings against entries with attr 0 and 7
    set_data(mk_dat(20'h12345, 1'b1, 2'd1));
    t_write(20'h00108, 1'b1, 6'b000000);
    set_data(mk_dat(20'h23456, 1'b1, 2'd2));
    t_write(20'h00110, 1'b1, 6'b101010);
    for (int p = 0; p < 64; p++) begin
      t_lookup("R9 attr0", 20'h00108, 6'(p));
      t_lookup("R9 attr7", 20'h00110, 6'(p));
    end

    // R7 guarded write
    set_data(mk_dat(20'h77777, 1'b0, 2'd1));
    t_write(20'h0AB03, 1'b1, 6'b111111);
    check_lk("R7 ignored", 20'h0AB03);
    check_lk("R7 ignored old", lpn_of(3, 1));
    set_data(mk_dat(20'h77777, 1'b1, 2'd2));
    t_write(20'h0AB05, 1'b1, 6'b100110);
    check_lk("R7 written", 20'h0AB05);
    check_lk("R7 replaced", lpn_of(5, 2));
    t_write(20'h0AB05, 1'b0, 6'b100110);
    check_lk("R7 invalidate", 20'h0AB05);

    // R10 duplicate entries; R3 normal path takes lowest way
    set_data(mk_dat(20'h11111, 1'b1, 2'd3));
    t_write(20'h0CC06, 1'b1, 6'b010101);
    set_data(mk_dat(20'h22222, 1'b1, 2'd1));
    t_write(20'h0CC06, 1'b1, 6'b101010);
    t_lookup("R10 duplicate", 20'h0CC06, 6'b111111);
    check_lk("R3 lowest way", 20'h0CC06);
    t_lookup("R9 R10 dup filtered", 20'h0CC06, 6'b011111);

    // R6 command readback and reserved bits
    cmd = 32'h0000_001E; cmd_we = 1'b1;
    cyc();
    m_write(20'h0, 1'b0, 6'b0);
    check("R6 readback", cmd_rb, 32'h0);
    t_lookup("R6", lpn_of(1, 2), 6'b111111);
    check("R6 readback lookup", cmd_rb, mk_cmd(lpn_of(1, 2), 1'b0, 6'b111111, 1'b1));

    // R12 data register mask and collision with lookup
    set_data(32'hFFFF_FFFF);
    check("R12 mask", data_rb, 32'hFFFF_F01C);
    data = 32'h0; data_we = 1'b1;
    t_lookup("R12 lookup wins", lpn_of(2, 3), 6'b111111);

    // R11 fill collides with effective test write
    set_data(mk_dat(20'h33333, 1'b1, 2'd0));
    fill = 1'b1; fill_lpn = 20'h0DD04; fill_ppn = 20'h44444; fill_attr = 3'd5;
    t_write(20'h0EE04, 1'b1, 6'b111111);
    check_lk("R11 fill dropped", 20'h0DD04);
    check_lk("R11 write kept", 20'h0EE04);
    do_fill(20'h0DD04, 20'h44444, 3'd5);
    t_lookup("R11 ptr held", 20'h0DD04, 6'b111111);

    // R11 flush collides with fill
    flush = 1'b1; fill = 1'b1; fill_lpn = 20'h0F007; fill_ppn = 20'h1; fill_attr = 3'd1;
    cyc();
    for (int s = 0; s < 8; s++) for (int w = 0; w < 4; w++) mv[s][w] = 1'b0;
    check_lk("R11 flush beats fill", 20'h0F007);
    for (int s = 0; s < 8; s++)
      for (int k = 1; k < 4; k++) check_lk("R5 flushed", lpn_of(s, k));

    // R5 pointers survive flush
    for (int s = 0; s < 8; s++) begin
      do_fill(lpn_of(s, 12), 20'h60000 + 20'(s), 3'd2);
      t_lookup("R5 ptr kept", lpn_of(s, 12), 6'b111111);
    end

    // R11 flush collides with test write
    set_data(mk_dat(20'h55555, 1'b1, 2'd3));
    flush = 1'b1;
    t_write(20'h0F100, 1'b1, 6'b111111);
    for (int s = 0; s < 8; s++) for (int w = 0; w < 4; w++) mv[s][w] = 1'b0;
    check_lk("R11 flush beats write", 20'h0F100);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule